// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block gives software register-level control over a large set of general-purpose pins. The pins are split into 32-bit banks, and each bank has its own group of word registers on a simple synchronous bus. Each group holds a direction register, an output latch, and two pulse ports that set or clear latch bits without a read-modify-write. A fifth word returns the pin levels after they pass through a two-stage synchronizer.

Software selects a bank and a register by address, writes through `bus_wr`/`bus_wdata`, and sees read data on `bus_rdata` one clock after it presents the address. The block drives the pad-side level (`pin_out`) and the output enable (`pin_oe`), and it samples the pad level on `pin_in`. There is no state machine. All state sits in per-bank latches and the synchronizer flops.

Top module: `gpio_bank_rf`

## Requirements
- R1: After reset every direction bit is 1 (input), the output latch is zero, `pin_oe` and `pin_out` are all zero, and `bus_rdata` is zero.
- R2: Bank b's register group starts at byte address 0x10 + 0x28*b. Inside the group, the direction register is at word offset 0x00, output data at 0x04, set port at 0x08, clear port at 0x0C and input data at 0x10. `bus_rdata` shows the word addressed in the previous cycle.
- R3: A direction bit of 1 makes the pin an input (`pin_oe` low) and a bit of 0 makes it an output (`pin_oe` high). A write to the direction register replaces all of its bits.
- R4: A write to the output-data word replaces the whole latch, and `pin_out` follows the latch.
- R5: A write to the set port turns on every latch bit whose write-data bit is 1 and leaves the other bits as they were. Reading the set or clear port returns the current latch.
- R6: A write to the clear port turns off every latch bit whose write-data bit is 1 and leaves the other bits as they were.
- R7: The input-data word shows `pin_in` through two flip-flop stages. A level applied between edges first appears in a read whose capture edge is the third edge after the change. The pin level is returned whatever the direction setting.
- R8: Reads return zero, and writes change nothing, for addresses below 0x10, for the unused offsets 0x14 to 0x24 inside a group, for addresses past the last configured bank, and for addresses that are not word-aligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and synchronizer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | BANK_W | Write data |
| bus_rdata | output | BANK_W | Registered read data for the previous cycle's address |
| pin_out | output | NUM_PINS | Output level for each pin |
| pin_oe | output | NUM_PINS | Output enable for each pin, high when the pin is an output |
| pin_in | input | NUM_PINS | Pad level for each pin, asynchronous |

## Verification
The assertions assume that `pin_in` is seen only at clock edges and that the bus inputs are stable around each edge. The synchronizer property then compares its output with the input from two sampled cycles earlier. The stimulus changes every input at the falling edge. Before any input-data read is compared, it keeps `pin_in` steady for at least three edges, except in the directed test that measures the exact latency. Random addresses cover mapped words, interrupt-area offsets, misaligned and out-of-range bytes.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;

    typedef enum logic [2:0] {
        REG_DIR,
        REG_OUT,
        REG_SET,
        REG_CLR,
        REG_IN,
        REG_NONE
    } reg_sel_e;

    localparam logic [5:0] OFF_DIR = 6'h00;
    localparam logic [5:0] OFF_OUT = 6'h04;
    localparam logic [5:0] OFF_SET = 6'h08;
    localparam logic [5:0] OFF_CLR = 6'h0C;
    localparam logic [5:0] OFF_IN  = 6'h10;

    function automatic reg_sel_e sel_of(input logic [5:0] off);
        reg_sel_e s;
        unique case (off)
            OFF_DIR: s = REG_DIR;
            OFF_OUT: s = REG_OUT;
            OFF_SET: s = REG_SET;
            OFF_CLR: s = REG_CLR;
            OFF_IN:  s = REG_IN;
            default: s = REG_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_rf_decode.sv
module gpio_rf_decode
    import gpio_rf_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int NUM_BANKS    = 5,
    parameter int GROUP_BASE   = 16,
    parameter int GROUP_STRIDE = 40
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] bank_hit,
    output reg_sel_e             sel
);

    logic [NUM_BANKS-1:0] raw_hit;
    logic [5:0]           off_w;
    logic                 aligned;

    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        raw_hit = '0;
        off_w   = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(addr) >= GROUP_BASE + b * GROUP_STRIDE &&
                int'(addr) <  GROUP_BASE + (b + 1) * GROUP_STRIDE) begin
                raw_hit[b] = 1'b1;
                off_w      = 6'(int'(addr) - (GROUP_BASE + b * GROUP_STRIDE));
            end
        end
    end

    always_comb begin
        reg_sel_e s;
        s = sel_of(off_w);
        if (aligned && (raw_hit != '0) && (s != REG_NONE)) begin
            bank_hit = raw_hit;
            sel      = s;
        end else begin
            bank_hit = '0;
            sel      = REG_NONE;
        end
    end

endmodule

// File: rtl/gpio_rf_bank.sv
module gpio_rf_bank #(
    parameter int WIDTH      = 32,
    parameter int VALID_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dir,
    input  logic             wr_out,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] out_q
);

    localparam logic [WIDTH-1:0] MASK = WIDTH'((64'd1 << VALID_BITS) - 64'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= MASK;
        end else if (wr_dir) begin
            dir_q <= wdata & MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr_out) begin
            out_q <= wdata & MASK;
        end else if (wr_set) begin
            out_q <= out_q | (wdata & MASK);
        end else if (wr_clr) begin
            out_q <= out_q & ~wdata;
        end
    end

    AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set && !wr_out |=> ((out_q & $past(out_q)) == $past(out_q)) &&
                              ((out_q & $past(wdata & MASK)) == $past(wdata & MASK))) // R5
        else $error("set port lost or missed a bit");

    AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr && !wr_out && !wr_set |=> ((out_q & $past(wdata)) == '0) &&
                                         ((out_q & ~$past(out_q)) == '0)) // R6
        else $error("clear port raised or kept a bit");

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_dir || wr_out || wr_set || wr_clr) |=> $stable(out_q) && $stable(dir_q)) // R8
        else $error("bank state changed without a write");

endmodule

// File: rtl/gpio_rf_sync.sv
module gpio_rf_sync #(
    parameter int WIDTH = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage1;
    logic [1:0]       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= 2'd0;
        end else if (warm != 2'd2) begin
            warm <= warm + 2'd1;
        end
    end

    AST_SYNC_TWO_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (q == $past(d, 2))) // R7
        else $error("synchronizer latency is not two cycles");

endmodule

// File: rtl/gpio_bank_rf.sv
module gpio_bank_rf
    import gpio_rf_pkg::*;
#(
    parameter int NUM_PINS     = 160,
    parameter int BANK_W       = 32,
    parameter int ADDR_W       = 8,
    parameter int GROUP_BASE   = 16,
    parameter int GROUP_STRIDE = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [BANK_W-1:0]   bus_wdata,
    output logic [BANK_W-1:0]   bus_rdata,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    input  logic [NUM_PINS-1:0] pin_in
);

    localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int PAD_W     = NUM_BANKS * BANK_W;

    logic [NUM_BANKS-1:0] bank_hit;
    reg_sel_e             sel;
    logic [PAD_W-1:0]     dir_all;
    logic [PAD_W-1:0]     out_all;
    logic [PAD_W-1:0]     in_all;
    logic [NUM_PINS-1:0]  in_sync;
    logic [BANK_W-1:0]    rd_next;
    logic                 miss_q;

    gpio_rf_decode #(
        .ADDR_W       (ADDR_W),
        .NUM_BANKS    (NUM_BANKS),
        .GROUP_BASE   (GROUP_BASE),
        .GROUP_STRIDE (GROUP_STRIDE)
    ) u_decode (
        .addr     (bus_addr),
        .bank_hit (bank_hit),
        .sel      (sel)
    );

    gpio_rf_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (in_sync)
    );

    always_comb begin
        in_all               = '0;
        in_all[NUM_PINS-1:0] = in_sync;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LEFT  = NUM_PINS - b * BANK_W;
        localparam int VALID = (LEFT < BANK_W) ? LEFT : BANK_W;
        logic hit_wr;
        assign hit_wr = bus_wr && bank_hit[b];

        gpio_rf_bank #(
            .WIDTH      (BANK_W),
            .VALID_BITS (VALID)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_dir (hit_wr && (sel == REG_DIR)),
            .wr_out (hit_wr && (sel == REG_OUT)),
            .wr_set (hit_wr && (sel == REG_SET)),
            .wr_clr (hit_wr && (sel == REG_CLR)),
            .wdata  (bus_wdata),
            .dir_q  (dir_all[b*BANK_W +: BANK_W]),
            .out_q  (out_all[b*BANK_W +: BANK_W])
        );
    end

    assign pin_out = out_all[NUM_PINS-1:0];
    assign pin_oe  = ~dir_all[NUM_PINS-1:0];

    always_comb begin
        rd_next = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) begin
                unique case (sel)
                    REG_DIR: rd_next = dir_all[b*BANK_W +: BANK_W];
                    REG_OUT,
                    REG_SET,
                    REG_CLR: rd_next = out_all[b*BANK_W +: BANK_W];
                    REG_IN:  rd_next = in_all[b*BANK_W +: BANK_W];
                    default: rd_next = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            miss_q    <= 1'b1;
        end else begin
            bus_rdata <= rd_next;
            miss_q    <= (bank_hit == '0);
        end
    end

    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_hit)) // R2
        else $error("address selects more than one bank");

    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q |-> (bus_rdata == '0)) // R8
        else $error("unmapped read returned data");

    AST_RESET_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0) && (pin_out == '0)) // R1
        else $error("pins not in reset state");

endmodule

// File: tb/gpio_bank_rf_test.sv
`timescale 1ns/100ps
module gpio_bank_rf_test;

    localparam int NP = 160;
    localparam int NB = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic [NP-1:0] pin_in = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0]   dir_m [NB];
    logic [31:0]   out_m [NB];
    logic [NP-1:0] pins_m;

    always #2.5 clk = ~clk;

    gpio_bank_rf uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_in    (pin_in)
    );

    // decode per R2/R8: returns bank and word offset, or -1 when unmapped
    function automatic int map_bank(input logic [7:0] a, output int off);
        int rel;
        off = -1;
        if (a[1:0] != 2'b00 || a < 8'h10) return -1;
        rel = int'(a) - 16;
        if (rel / 40 >= NB) return -1;
        off = rel % 40;
        if (off > 16) return -1;
        return rel / 40;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int off;
        int b;
        b = map_bank(a, off);
        if (b < 0) return '0;
        case (off)
            0:       return dir_m[b];
            4, 8, 12: return out_m[b];
            16:      return pins_m[b*32 +: 32];
            default: return '0;
        endcase
    endfunction

    function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
        int off;
        int b;
        b = map_bank(a, off);
        if (b < 0) return;
        case (off)
            0:  dir_m[b] = d;
            4:  out_m[b] = d;
            8:  out_m[b] = out_m[b] | d;
            12: out_m[b] = out_m[b] & ~d;
            default: ;
        endcase
    endfunction

    function automatic logic [NP-1:0] exp_out();
        logic [NP-1:0] v;
        for (int b = 0; b < NB; b++) v[b*32 +: 32] = out_m[b];
        return v;
    endfunction

    function automatic logic [NP-1:0] exp_oe();
        logic [NP-1:0] v;
        for (int b = 0; b < NB; b++) v[b*32 +: 32] = ~dir_m[b];
        return v;
    endfunction

    task automatic check(input string tag, input logic [NP-1:0] got, input logic [NP-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic read_check(input string tag, input logic [7:0] a);
        @(negedge clk);
        bus_addr = a;
        bus_wr   = 1'b0;
        @(negedge clk);
        check(tag, NP'(bus_rdata), NP'(exp_read(a)));
    endtask

    task automatic pins_check(input string tag);
        check({tag, " pin_out"}, pin_out, exp_out());
        check({tag, " pin_oe"}, pin_oe, exp_oe());
    endtask

    task automatic set_pins(input logic [NP-1:0] v);
        @(negedge clk);
        pin_in = v;
        pins_m = v;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [7:0] grp(input int b, input int off);
        return 8'(16 + 40 * b + off);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'h5EED_0001);
        for (int b = 0; b < NB; b++) begin
            dir_m[b] = '1;
            out_m[b] = '0;
        end
        pins_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rdata", NP'(bus_rdata), '0);
        pins_check("R1");
        read_check("R1 dir bank0", grp(0, 0));
        read_check("R1 out bank4", grp(4, 4));

        // R2 group placement: distinct value per bank
        for (int b = 0; b < NB; b++) bus_write(grp(b, 4), 32'hA500_0000 | 32'(b * 7 + 1));
        for (int b = 0; b < NB; b++) read_check("R2 out per bank", grp(b, 4));
        pins_check("R2");

        // R3 direction
        bus_write(grp(2, 0), 32'h0000_FFFF);
        pins_check("R3");
        read_check("R3 dir read", grp(2, 0));

        // R4 whole-latch replace
        bus_write(grp(1, 4), 32'h0F0F_0000);
        pins_check("R4");

        // R5 set port, readback of set/clr words
        bus_write(grp(1, 8), 32'h0000_00FF);
        check("R5 latch", NP'(pin_out[32 +: 32]), NP'(32'h0F0F_00FF));
        read_check("R5 read set word", grp(1, 8));
        read_check("R5 read clr word", grp(1, 12));

        // R6 clear port
        bus_write(grp(1, 12), 32'h0F00_0001);
        check("R6 latch", NP'(pin_out[32 +: 32]), NP'(32'h000F_00FE));
        pins_check("R6");

        // R7 exact two-stage latency on bank 0 input word
        @(negedge clk);
        bus_addr = grp(0, 16);
        pin_in   = {NP{1'b0}} | NP'(32'hDEAD_BEEF);
        @(negedge clk);
        check("R7 edge1 old", NP'(bus_rdata), '0);
        @(negedge clk);
        check("R7 edge2 old", NP'(bus_rdata), '0);
        @(negedge clk);
        check("R7 edge3 new", NP'(bus_rdata), NP'(32'hDEAD_BEEF));
        pins_m = pin_in;
        // R7 level returned while configured as output
        bus_write(grp(3, 0), 32'h0);
        set_pins({32'h1234_5678, 32'h9ABC_DEF0, 32'h0F1E_2D3C, 32'h4B5A_6978, 32'h8796_A5B4});
        read_check("R7 output-dir readback", grp(3, 16));

        // R8 ignored addresses
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(grp(0, 20), 32'hFFFF_FFFF);
        bus_write(grp(2, 36), 32'hFFFF_FFFF);
        bus_write(8'hD8, 32'hFFFF_FFFF);
        bus_write(grp(1, 5), 32'hFFFF_FFFF);
        pins_check("R8 after stray writes");
        read_check("R8 low addr", 8'h08);
        read_check("R8 irq area", grp(0, 24));
        read_check("R8 past end", 8'hF0);
        read_check("R8 misaligned", grp(0, 2));

        // mixed random phase
        for (int i = 0; i < 600; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            int          pick;
            if (i % 60 == 0)
                set_pins({$urandom, $urandom, $urandom, $urandom, $urandom});
            pick = int'($urandom % 10);
            if (pick < 8) a = grp(int'($urandom % NB), int'($urandom % 5) * 4);
            else          a = 8'($urandom);
            d = $urandom;
            if ($urandom % 2 == 0) begin
                bus_write(a, d);
                pins_check("R3/R4/R5/R6/R8 random write");
            end else begin
                read_check("R2/R7/R8 random read", a);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule